// File: doc/BRIEF.md
# Write-Validate Store Cache

This block is a small set-associative cache that sits beside a larger level-two cache and takes in the processor's store traffic. It is the only place on the chip where modified data lives. Every byte it holds counts as dirty. When a store misses, the block allocates a line without asking level two for the rest of it. The line then carries a per-byte valid mask, and only the bytes that stores have written are marked.

Loads look the cache up in parallel with their level-two access. The level-two word comes in alongside the load request. The block returns a word in which every byte the cache holds replaces the corresponding level-two byte. When a set is full, a store miss picks its victim round-robin. The victim line goes out on an eviction port with its line address, its data and its byte mask. The store is held off until that port accepts the line.

The default geometry is 2 KB: 8 sets, 4 ways, 64-byte lines. Stores and loads are one 8-byte word wide. The low three address bits of both ports are ignored.

Top module: `wvc_store_cache`

## Requirements
- R1: After reset no line is valid, `ev_valid` is 0 and `st_ready` is 1. A load then returns `ld_l2_data` unchanged with `ld_hit` = 0.
- R2: A store that misses allocates a line without any level-two fetch. Only the bytes it enables are marked valid. A store whose byte enables are all zero is accepted and changes nothing, so a later load to that line still misses.
- R3: On a load that hits, byte i of `ld_rdata` (bits 8i+7..8i) is the cached byte when that byte is valid, and otherwise byte i of `ld_l2_data`.
- R4: A store that hits overwrites only its enabled bytes. It adds them to the line's valid mask and leaves earlier valid bytes in place.
- R5: A load that misses returns `ld_l2_data` unchanged with `ld_hit` = 0, and it allocates nothing.
- R6: A set that is full and takes a store miss evicts its ways in round-robin order. Each set keeps its own pointer, and the oldest allocated line leaves first. `ev_valid` is raised, and `ev_addr` carries the victim's byte address with the offset bits at zero.
- R7: While an eviction is pending and `ev_ready` is 0, `st_ready` is 0 and the store has no effect. `ev_valid` is 1 only during a store that needs an eviction.
- R8: A load and a store to the same line in one cycle: the load returns the contents from before the store.
- R9: Load results appear one cycle after the request. `ld_rvalid` is 1 exactly in the cycle after a cycle with `ld_valid` = 1.
- R10: `ev_mask` bit i is the victim's valid bit for byte i. `ev_data` byte i is the cached byte where that bit is set and zero elsewhere. A line's whole valid contents leave on eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request |
| st_ready | output | 1 | Store accepted this cycle |
| st_addr | input | 32 | Store byte address (word aligned) |
| st_data | input | 64 | Store data word |
| st_be | input | 8 | Store byte enables |
| ld_valid | input | 1 | Load lookup request |
| ld_addr | input | 32 | Load byte address (word aligned) |
| ld_l2_data | input | 64 | Level-two word for the load |
| ld_rvalid | output | 1 | Load result valid |
| ld_hit | output | 1 | Load found its line |
| ld_rdata | output | 64 | Merged load word |
| ev_valid | output | 1 | Eviction line offered |
| ev_ready | input | 1 | Eviction accepted |
| ev_addr | output | 32 | Victim line byte address |
| ev_data | output | 512 | Victim line data, invalid bytes zeroed |
| ev_mask | output | 64 | Victim byte valid mask |

## Verification
The bench drives stores that hit, stores that allocate and stores with no enables. A design that fetched on allocation, or that kept the old mask on reuse, would return stale bytes where level-two bytes belong. It aims a load and a store at the same line in one cycle. A design that forwarded the store would return the new bytes a cycle early. It fills sets past capacity while `ev_ready` is held low. A broken round-robin pointer would then evict the wrong tag, and a missing stall would lose a line or drop a store. Over long random runs with a behavioural model, the eviction data is compared with the bytes that should have been kept. Masking errors would show up as stray bytes in the unmasked positions.

// File: rtl/wvc_pkg.sv
package wvc_pkg;
   // What a presented store does this cycle.
   typedef enum logic [1:0] {
      OP_NONE,
      OP_HIT,
      OP_ALLOC,
      OP_STALL
   } wvc_st_op_e;
endpackage

// File: rtl/wvc_byte_merge.sv
// Byte-wise selector: own byte where the mask bit is set, else alternate byte.
module wvc_byte_merge #(
   parameter int NBYTES = 8
) (
   input  logic [NBYTES*8-1:0] own_data,
   input  logic [NBYTES-1:0]   own_mask,
   input  logic [NBYTES*8-1:0] alt_data,
   output logic [NBYTES*8-1:0] merged
);
   for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign merged[b*8 +: 8] = own_mask[b] ? own_data[b*8 +: 8] : alt_data[b*8 +: 8];
   end
endmodule

// File: rtl/wvc_tag_array.sv
// Tags, line-valid bits and per-set round-robin pointers.
module wvc_tag_array #(
   parameter int SETS  = 8,
   parameter int WAYS  = 4,
   parameter int TAG_W = 23,
   localparam int SET_W = $clog2(SETS),
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] st_set,
   input  logic [TAG_W-1:0] st_tag,
   input  logic             alloc_en,
   output logic             st_hit,
   output logic [WAY_W-1:0] st_hit_way,
   output logic [WAY_W-1:0] victim_way,
   output logic             victim_valid,
   output logic [TAG_W-1:0] victim_tag,
   input  logic [SET_W-1:0] ld_set,
   input  logic [TAG_W-1:0] ld_tag,
   output logic             ld_hit,
   output logic [WAY_W-1:0] ld_hit_way
);
   logic [TAG_W-1:0] tag_q [SETS][WAYS];
   logic [WAYS-1:0]  vld_q [SETS];
   logic [WAY_W-1:0] rr_q  [SETS];

   logic [WAYS-1:0] st_match;
   logic [WAYS-1:0] ld_match;

   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign st_match[w] = vld_q[st_set][w] && (tag_q[st_set][w] == st_tag);
      assign ld_match[w] = vld_q[ld_set][w] && (tag_q[ld_set][w] == ld_tag);
   end

   always_comb begin
      st_hit_way = '0;
      ld_hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (st_match[w]) st_hit_way = WAY_W'(w);
         if (ld_match[w]) ld_hit_way = WAY_W'(w);
      end
   end

   assign st_hit       = |st_match;
   assign ld_hit       = |ld_match;
   assign victim_way   = rr_q[st_set];
   assign victim_valid = vld_q[st_set][victim_way];
   assign victim_tag   = tag_q[st_set][victim_way];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            rr_q[s]  <= '0;
         end
      end else if (alloc_en) begin
         tag_q[st_set][victim_way] <= st_tag;
         vld_q[st_set][victim_way] <= 1'b1;
         rr_q[st_set]              <= victim_way + 1'b1;
      end
   end
endmodule

// File: rtl/wvc_data_array.sv
// Line data and per-byte valid masks, with a word write port,
// a word read port for loads and a full-line read port for eviction.
module wvc_data_array #(
   parameter int LINES      = 32,
   parameter int LINE_BYTES = 64,
   parameter int WORD_BYTES = 8,
   localparam int LIDX_W = $clog2(LINES),
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int BSEL_W = $clog2(WORD_BYTES),
   localparam int WSEL_W = OFF_W - BSEL_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    wr_clear,
   input  logic [LIDX_W-1:0]       wr_line,
   input  logic [WSEL_W-1:0]       wr_word,
   input  logic [WORD_BYTES*8-1:0] wr_data,
   input  logic [WORD_BYTES-1:0]   wr_be,
   input  logic [LIDX_W-1:0]       rd_line,
   input  logic [WSEL_W-1:0]       rd_word,
   output logic [WORD_BYTES*8-1:0] rd_data,
   output logic [WORD_BYTES-1:0]   rd_mask,
   input  logic [LIDX_W-1:0]       ev_line,
   output logic [LINE_BYTES*8-1:0] ev_data,
   output logic [LINE_BYTES-1:0]   ev_mask
);
   logic [LINE_BYTES*8-1:0] dat_q [LINES];
   logic [LINE_BYTES-1:0]   msk_q [LINES];

   logic [OFF_W-1:0]      wr_base;
   logic [OFF_W-1:0]      rd_base;
   logic [LINE_BYTES-1:0] wr_bits;

   assign wr_base = {wr_word, {BSEL_W{1'b0}}};
   assign rd_base = {rd_word, {BSEL_W{1'b0}}};
   assign wr_bits = {{(LINE_BYTES-WORD_BYTES){1'b0}}, wr_be} << wr_base;

   always_ff @(posedge clk) begin
      for (int b = 0; b < WORD_BYTES; b++) begin
         if (wr_en && wr_be[b]) begin
            dat_q[wr_line][(int'(wr_base) + b)*8 +: 8] <= wr_data[b*8 +: 8];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int l = 0; l < LINES; l++) msk_q[l] <= '0;
      end else if (wr_en) begin
         msk_q[wr_line] <= wr_clear ? wr_bits : (msk_q[wr_line] | wr_bits);
      end
   end

   assign rd_data = dat_q[rd_line][int'(rd_base)*8 +: WORD_BYTES*8];
   assign rd_mask = msk_q[rd_line][rd_base +: WORD_BYTES];
   assign ev_data = dat_q[ev_line];
   assign ev_mask = msk_q[ev_line];
endmodule

// File: rtl/wvc_store_cache.sv
// Write-validate store cache top level.
module wvc_store_cache #(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 8,
   parameter int WAYS       = 4,
   parameter int LINE_BYTES = 64,
   parameter int WORD_BYTES = 8,
   parameter bit LD_PIPE    = 1'b1,
   localparam int OFF_W  = $clog2(LINE_BYTES),
   localparam int SET_W  = $clog2(SETS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int BSEL_W = $clog2(WORD_BYTES),
   localparam int WSEL_W = OFF_W - BSEL_W,
   localparam int TAG_W  = ADDR_W - OFF_W - SET_W,
   localparam int LINES  = SETS * WAYS,
   localparam int LIDX_W = SET_W + WAY_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    st_valid,
   output logic                    st_ready,
   input  logic [ADDR_W-1:0]       st_addr,
   input  logic [WORD_BYTES*8-1:0] st_data,
   input  logic [WORD_BYTES-1:0]   st_be,
   input  logic                    ld_valid,
   input  logic [ADDR_W-1:0]       ld_addr,
   input  logic [WORD_BYTES*8-1:0] ld_l2_data,
   output logic                    ld_rvalid,
   output logic                    ld_hit,
   output logic [WORD_BYTES*8-1:0] ld_rdata,
   output logic                    ev_valid,
   input  logic                    ev_ready,
   output logic [ADDR_W-1:0]       ev_addr,
   output logic [LINE_BYTES*8-1:0] ev_data,
   output logic [LINE_BYTES-1:0]   ev_mask
);
   import wvc_pkg::*;

   // Elaboration-time parameter checks.
   if ((WAYS < 2) || ((WAYS & (WAYS - 1)) != 0)) begin : g_bad_ways
      $error("WAYS must be a power of two and at least 2");
   end
   if ((SETS < 2) || ((SETS & (SETS - 1)) != 0)) begin : g_bad_sets
      $error("SETS must be a power of two and at least 2");
   end
   if ((WORD_BYTES < 2) || ((WORD_BYTES & (WORD_BYTES - 1)) != 0)) begin : g_bad_word
      $error("WORD_BYTES must be a power of two and at least 2");
   end
   if ((LINE_BYTES <= WORD_BYTES) || ((LINE_BYTES & (LINE_BYTES - 1)) != 0)) begin : g_bad_line
      $error("LINE_BYTES must be a power of two larger than WORD_BYTES");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   // Address fields.
   logic [SET_W-1:0]  st_set, ld_set;
   logic [TAG_W-1:0]  st_tag, ld_tag;
   logic [WSEL_W-1:0] st_word, ld_word;
   logic              unused_low;

   assign st_tag     = st_addr[ADDR_W-1 -: TAG_W];
   assign st_set     = st_addr[OFF_W +: SET_W];
   assign st_word    = st_addr[BSEL_W +: WSEL_W];
   assign ld_tag     = ld_addr[ADDR_W-1 -: TAG_W];
   assign ld_set     = ld_addr[OFF_W +: SET_W];
   assign ld_word    = ld_addr[BSEL_W +: WSEL_W];
   assign unused_low = ^{st_addr[BSEL_W-1:0], ld_addr[BSEL_W-1:0]};

   // Tag lookup.
   logic             st_hit, victim_valid, ld_line_hit, alloc_en;
   logic [WAY_W-1:0] st_hit_way, victim_way, ld_hit_way;
   logic [TAG_W-1:0] victim_tag;

   wvc_tag_array #(
      .SETS (SETS),
      .WAYS (WAYS),
      .TAG_W(TAG_W)
   ) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .st_set      (st_set),
      .st_tag      (st_tag),
      .alloc_en    (alloc_en),
      .st_hit      (st_hit),
      .st_hit_way  (st_hit_way),
      .victim_way  (victim_way),
      .victim_valid(victim_valid),
      .victim_tag  (victim_tag),
      .ld_set      (ld_set),
      .ld_tag      (ld_tag),
      .ld_hit      (ld_line_hit),
      .ld_hit_way  (ld_hit_way)
   );

   // Store decision.
   wvc_st_op_e st_op;
   logic       st_active;

   assign st_active = st_valid && (st_be != '0);

   always_comb begin
      st_op = OP_NONE;
      if (st_active) begin
         if (st_hit)                       st_op = OP_HIT;
         else if (victim_valid && !ev_ready) st_op = OP_STALL;
         else                              st_op = OP_ALLOC;
      end
   end

   assign st_ready = (st_op != OP_STALL);
   assign alloc_en = (st_op == OP_ALLOC);
   assign ev_valid = st_active && !st_hit && victim_valid;
   assign ev_addr  = {victim_tag, st_set, {OFF_W{1'b0}}};

   // Data and mask storage.
   logic                    wr_en;
   logic [LIDX_W-1:0]       wr_line, rd_line, ev_line;
   logic [WORD_BYTES*8-1:0] rd_data;
   logic [WORD_BYTES-1:0]   rd_mask, ld_mask;
   logic [LINE_BYTES*8-1:0] ev_raw;

   assign wr_en   = (st_op == OP_HIT) || (st_op == OP_ALLOC);
   assign wr_line = {st_set, st_hit ? st_hit_way : victim_way};
   assign rd_line = {ld_set, ld_hit_way};
   assign ev_line = {st_set, victim_way};

   wvc_data_array #(
      .LINES     (LINES),
      .LINE_BYTES(LINE_BYTES),
      .WORD_BYTES(WORD_BYTES)
   ) u_data (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_clear(alloc_en),
      .wr_line (wr_line),
      .wr_word (st_word),
      .wr_data (st_data),
      .wr_be   (st_be),
      .rd_line (rd_line),
      .rd_word (ld_word),
      .rd_data (rd_data),
      .rd_mask (rd_mask),
      .ev_line (ev_line),
      .ev_data (ev_raw),
      .ev_mask (ev_mask)
   );

   // Eviction data: invalid bytes forced to zero.
   wvc_byte_merge #(.NBYTES(LINE_BYTES)) u_ev_merge (
      .own_data(ev_raw),
      .own_mask(ev_mask),
      .alt_data('0),
      .merged  (ev_data)
   );

   // Load merge with level-two word.
   logic [WORD_BYTES*8-1:0] ld_merged;

   assign ld_mask = ld_line_hit ? rd_mask : '0;

   wvc_byte_merge #(.NBYTES(WORD_BYTES)) u_ld_merge (
      .own_data(rd_data),
      .own_mask(ld_mask),
      .alt_data(ld_l2_data),
      .merged  (ld_merged)
   );

   if (LD_PIPE) begin : g_ld_reg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ld_rvalid <= 1'b0;
            ld_hit    <= 1'b0;
            ld_rdata  <= '0;
         end else begin
            ld_rvalid <= ld_valid;
            ld_hit    <= ld_valid && ld_line_hit;
            if (ld_valid) ld_rdata <= ld_merged;
         end
      end
   end else begin : g_ld_comb
      assign ld_rvalid = ld_valid;
      assign ld_hit    = ld_valid && ld_line_hit;
      assign ld_rdata  = ld_merged;
   end
endmodule

// File: rtl/wvc_store_cache_chk.sv
// Property checker attached to every instance of the top module.
module wvc_store_cache_chk #(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int WORD_BYTES = 8,
   parameter bit LD_PIPE    = 1'b1
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    st_valid,
   input logic                    st_ready,
   input logic                    ld_valid,
   input logic [WORD_BYTES*8-1:0] ld_l2_data,
   input logic                    ld_rvalid,
   input logic                    ld_hit,
   input logic [WORD_BYTES*8-1:0] ld_rdata,
   input logic                    ev_valid,
   input logic                    ev_ready,
   input logic [LINE_BYTES-1:0]   ev_mask,
   input logic [ADDR_W-1:0]       ev_addr
);
   logic unused_addr;
   assign unused_addr = ^ev_addr;

   // R7: a refused eviction holds the store off
   a_r7_stall_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid && !ev_ready |-> !st_ready);

   // R7: no store presented, nothing to refuse
   a_r7_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> st_ready);

   // R6: evictions only come from a presented store
   a_r6_ev_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> st_valid);

   // R10: an evicted line always carries some valid bytes
   a_r10_ev_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> (ev_mask != '0));

   if (LD_PIPE) begin : g_pipe_props
      // R9: one-cycle load latency
      a_r9_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
         ld_valid |=> ld_rvalid);
      a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
         !ld_valid |=> !ld_rvalid);
      // R5: a miss passes the level-two word through
      a_r5_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
         ld_rvalid && !ld_hit |-> ld_rdata == $past(ld_l2_data));
   end
endmodule

bind wvc_store_cache wvc_store_cache_chk #(
   .ADDR_W    (ADDR_W),
   .LINE_BYTES(LINE_BYTES),
   .WORD_BYTES(WORD_BYTES),
   .LD_PIPE   (LD_PIPE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .st_valid  (st_valid),
   .st_ready  (st_ready),
   .ld_valid  (ld_valid),
   .ld_l2_data(ld_l2_data),
   .ld_rvalid (ld_rvalid),
   .ld_hit    (ld_hit),
   .ld_rdata  (ld_rdata),
   .ev_valid  (ev_valid),
   .ev_ready  (ev_ready),
   .ev_mask   (ev_mask),
   .ev_addr   (ev_addr)
);

// File: tb/wvc_store_cache_tb_top.sv
module wvc_store_cache_tb_top;
   localparam int NSETS = 8;
   localparam int NWAYS = 4;
   localparam int LB    = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         st_valid = 1'b0;
   logic         st_ready;
   logic [31:0]  st_addr = '0;
   logic [63:0]  st_data = '0;
   logic [7:0]   st_be = '0;
   logic         ld_valid = 1'b0;
   logic [31:0]  ld_addr = '0;
   logic [63:0]  ld_l2_data = '0;
   logic         ld_rvalid;
   logic         ld_hit;
   logic [63:0]  ld_rdata;
   logic         ev_valid;
   logic         ev_ready = 1'b1;
   logic [31:0]  ev_addr;
   logic [511:0] ev_data;
   logic [63:0]  ev_mask;

   always #10 clk = ~clk;

   wvc_store_cache dut_i (
      .clk(clk), .rst_n(rst_n),
      .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
      .st_data(st_data), .st_be(st_be),
      .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_l2_data(ld_l2_data),
      .ld_rvalid(ld_rvalid), .ld_hit(ld_hit), .ld_rdata(ld_rdata),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_addr(ev_addr),
      .ev_data(ev_data), .ev_mask(ev_mask)
   );

   int errors = 0;
   int total  = 0;

   // Behavioural model: per set, tags in allocation order; bytes by address.
   int unsigned line_q [NSETS][$];
   bit [7:0]    mb [int unsigned];

   bit          p_rv = 0;
   bit          p_hit;
   bit [63:0]   p_rdata;
   string       p_tag = "R3";
   bit          last_acc = 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [511:0] act, input logic [511:0] exp);
      total++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic bit present(int s, int unsigned t);
      foreach (line_q[s][i]) if (line_q[s][i] == t) return 1'b1;
      return 1'b0;
   endfunction

   function automatic bit [31:0] mk(int unsigned t, int s, int w);
      return (t << 9) | (s << 6) | (w << 3);
   endfunction

   task automatic cycle(input bit sv, input bit [31:0] sa, input bit [63:0] sd,
                        input bit [7:0] sbe, input bit lv, input bit [31:0] la,
                        input bit [63:0] l2, input bit er, input string tag);
      int          s, ls;
      int unsigned t, lt, va;
      bit          act, hit, need;
      bit [63:0]   em;
      bit [511:0]  ed;
      @(negedge clk);
      st_valid = sv; st_addr = sa; st_data = sd; st_be = sbe;
      ld_valid = lv; ld_addr = la; ld_l2_data = l2; ev_ready = er;
      #2;
      // registered load result from the previous cycle
      chk(ld_rvalid === p_rv, "R9", "ld_rvalid", ld_rvalid, p_rv);
      if (p_rv) begin
         chk(ld_rdata === p_rdata, p_tag, "ld_rdata", ld_rdata, p_rdata);
         chk(ld_hit === p_hit, p_tag, "ld_hit", ld_hit, p_hit);
      end
      // store side expectations
      s = (sa >> 6) & (NSETS - 1);
      t = sa >> 9;
      act = sv && (sbe != 0);
      hit = present(s, t);
      need = act && !hit && (line_q[s].size() == NWAYS);
      chk(ev_valid === need, "R6", "ev_valid", ev_valid, need);
      chk(st_ready === (!need || er), "R7", "st_ready", st_ready, (!need || er));
      if (need) begin
         va = (line_q[s][0] << 9) | (s << 6);
         em = '0; ed = '0;
         for (int i = 0; i < LB; i++) begin
            if (mb.exists(va + i)) begin
               em[i] = 1'b1;
               ed[i*8 +: 8] = mb[va + i];
            end
         end
         chk(ev_addr === va, "R6", "ev_addr", ev_addr, va);
         chk(ev_mask === em, "R10", "ev_mask", ev_mask, em);
         chk(ev_data === ed, "R10", "ev_data", ev_data, ed);
      end
      // load sees state before this cycle's store
      p_rv = lv;
      p_tag = tag;
      if (lv) begin
         ls = (la >> 6) & (NSETS - 1);
         lt = la >> 9;
         p_hit = present(ls, lt);
         for (int i = 0; i < 8; i++) begin
            if (mb.exists((la & ~32'd7) + i)) p_rdata[i*8 +: 8] = mb[(la & ~32'd7) + i];
            else                              p_rdata[i*8 +: 8] = l2[i*8 +: 8];
         end
      end
      // store update
      last_acc = !need || er;
      if (act && last_acc) begin
         if (need) begin
            va = (line_q[s][0] << 9) | (s << 6);
            for (int i = 0; i < LB; i++) if (mb.exists(va + i)) mb.delete(va + i);
            void'(line_q[s].pop_front());
         end
         if (!hit) line_q[s].push_back(t);
         for (int i = 0; i < 8; i++)
            if (sbe[i]) mb[(sa & ~32'd7) + i] = sd[i*8 +: 8];
      end
   endtask

   task automatic idle(input string tag);
      cycle(0, 0, 0, 0, 0, 0, 0, 1, tag);
   endtask

   task automatic store(input bit [31:0] a, input bit [63:0] d, input bit [7:0] be,
                        input bit er, input string tag);
      cycle(1, a, d, be, 0, 0, 0, er, tag);
   endtask

   task automatic load(input bit [31:0] a, input bit [63:0] l2, input string tag);
      cycle(0, 0, 0, 0, 1, a, l2, 1, tag);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
   end

   initial begin
      bit [31:0] ra;
      bit [63:0] rd;
      bit [7:0]  rbe;
      bit        rsv;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1: reset state
      chk(ld_rvalid === 1'b0, "R1", "ld_rvalid after reset", ld_rvalid, 0);
      chk(ev_valid === 1'b0, "R1", "ev_valid after reset", ev_valid, 0);
      chk(st_ready === 1'b1, "R1", "st_ready after reset", st_ready, 1);
      load(mk(1, 0, 0), 64'h0123_4567_89AB_CDEF, "R1");
      load(mk(3, 6, 7), 64'hFEDC_BA98_7654_3210, "R1");

      // R2: write-validate allocation, merge on partial line
      store(mk(1, 0, 2), 64'h1122_3344_5566_7788, 8'h0F, 1, "R2");
      load(mk(1, 0, 2), 64'hAAAA_AAAA_AAAA_AAAA, "R2");
      load(mk(1, 0, 5), 64'h5555_5555_5555_5555, "R2");
      // R2: zero-enable store leaves nothing behind
      store(mk(2, 1, 0), 64'hDEAD_BEEF_DEAD_BEEF, 8'h00, 1, "R2");
      load(mk(2, 1, 0), 64'h0F0F_0F0F_0F0F_0F0F, "R2");

      // R4: store hits accumulate masks
      store(mk(1, 0, 2), 64'h99AA_BBCC_DDEE_FF00, 8'hF0, 1, "R4");
      store(mk(1, 0, 2), 64'h0000_1234_5678_0000, 8'h3C, 1, "R4");
      load(mk(1, 0, 2), 64'hCCCC_CCCC_CCCC_CCCC, "R4");

      // R5: miss passes through and does not allocate
      load(mk(5, 3, 1), 64'h1357_9BDF_2468_ACE0, "R5");
      load(mk(5, 3, 1), 64'h0BAD_F00D_0BAD_F00D, "R5");

      // R8: same-cycle store and load to one line
      cycle(1, mk(1, 0, 2), 64'hFFEE_DDCC_BBAA_9988, 8'hFF, 1, mk(1, 0, 2),
            64'h7777_7777_7777_7777, 1, "R8");
      load(mk(1, 0, 2), 64'h7777_7777_7777_7777, "R3");

      // R6/R7: fill set 0, then evict with the port busy
      store(mk(2, 0, 0), 64'h2222_2222_2222_2222, 8'h01, 1, "R6");
      store(mk(3, 0, 7), 64'h3333_3333_3333_3333, 8'h80, 1, "R6");
      store(mk(4, 0, 3), 64'h4444_4444_4444_4444, 8'hFF, 1, "R6");
      store(mk(6, 0, 1), 64'h6666_6666_6666_6666, 8'h18, 0, "R7");
      store(mk(6, 0, 1), 64'h6666_6666_6666_6666, 8'h18, 0, "R7");
      load(mk(1, 0, 2), 64'h0, "R7");
      store(mk(6, 0, 1), 64'h6666_6666_6666_6666, 8'h18, 1, "R6");
      load(mk(1, 0, 2), 64'h8888_8888_8888_8888, "R6");
      load(mk(2, 0, 0), 64'h8888_8888_8888_8888, "R6");
      store(mk(7, 0, 4), 64'h7070_7070_7070_7070, 8'h0F, 1, "R6");
      load(mk(2, 0, 0), 64'h9999_9999_9999_9999, "R6");

      // R6: another set keeps its own pointer
      for (int k = 0; k < 6; k++)
         store(mk(10 + k, 5, k), {8{8'(k + 1)}}, 8'h81, 1, "R6");
      load(mk(10, 5, 0), 64'h1111_0000_1111_0000, "R6");
      load(mk(12, 5, 2), 64'h1111_0000_1111_0000, "R6");

      // Random traffic against the model
      rsv = 0; ra = 0; rd = 0; rbe = 0;
      for (int n = 0; n < 4000; n++) begin
         if (last_acc || !rsv) begin
            rsv = ($urandom_range(0, 3) != 0);
            ra  = mk($urandom_range(0, 6), $urandom_range(0, 2), $urandom_range(0, 7));
            rd  = {$urandom, $urandom};
            rbe = 8'($urandom);
         end
         cycle(rsv, ra, rd, rbe, ($urandom_range(0, 1) == 1),
               mk($urandom_range(0, 6), $urandom_range(0, 2), $urandom_range(0, 7)),
               {$urandom, $urandom}, ($urandom_range(0, 3) != 0), "R3");
      end

      idle("R3");
      idle("R3");
      summary();
   end
endmodule